// File: doc/BRIEF.md
# Touch Converter Serial Command Front End

This block is the device side of the serial port of a touch-screen converter. It watches a data-in line that is clocked by the serial clock. The first high bit it sees while idle is a start bit, and the seven bits after it form a command. From the command the block decodes four things: a channel address, a resolution, a reference mode and a power setting. When the last command bit arrives, the block raises a one-clock busy flag and captures a parallel digital sample, which stands in for the analog hold-and-compare path. It then shifts the sample out MSB-first on data-out. After the last result bit, data-out stays low until the next result begins.

For touch channels, the block also runs a touch-driver enable. The drivers switch on while the command is still arriving. In single-ended mode they switch off at the hold point. In differential mode they stay on through the conversion. The power setting drives the reference-on, converter-on and pen-interrupt-enable outputs, but it changes only at the clock where busy rises. A new command may overlap the tail of the previous result once a fixed number of clocks has passed since the previous start bit.

Top module: `tsc_serial_if`

## Requirements
- R1: While no command is being received, a low `din` is ignored. The first high `din` sampled on a rising edge is the start bit. The next seven rising edges capture, in order: address A2, A1, A0; resolution (1 = 8-bit, 0 = 12-bit); reference mode (1 = single-ended, 0 = differential); and power bits P1, P0.
- R2: `busy` goes high on the rising edge that samples P0 (clock 8, with the start bit as clock 1). It stays high for exactly one clock and is low at every other time.
- R3: `sample_in` is captured on the edge where `busy` rises. Result bits leave MSB first on `dout`, which changes only on falling edges. Result bit i is valid at rising edge 10+i. A 12-bit command sends all 12 bits; an 8-bit command sends the upper 8 bits.
- R4: Once the last result bit has been presented, `dout` is low until the next result starts.
- R5: A new start bit is accepted no earlier than 15 clocks after the previous start bit when the previous command was 12-bit, and 11 clocks after it when it was 8-bit. A high `din` before that clock is ignored.
- R6: For a touch address (1, 3, 4 or 5 with the default mask), `drv_en` goes high from the rising edge that samples the reference-mode bit. In single-ended mode it drops on the edge where `busy` rises. In differential mode it stays high through the busy clock and every result bit, which is 13 clocks for a 12-bit result. It drops at the edge that samples the last bit.
- R7: `drv_en` is never high for a non-touch address. A differential request on such an address is handled as single-ended.
- R8: `ref_on` equals the latched P1 and `pen_irq_en` equals the inverse of the latched P0. Both change only on the edge where `busy` rises. After reset, the latched code is 00.
- R9: `adc_on` is high whenever the latched P0 is 1. When P0 is 0, `adc_on` is high only during the busy clock and while result bits remain to be presented.
- R10: `mux_sel` takes the address from the rising edge that samples the reference-mode bit and holds it until the next command reaches that edge.
- R11: After reset, `dout`, `busy`, `drv_en`, `ref_on`, `adc_on` and `mux_sel` are 0, and `pen_irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; `din` sampled on rise, `dout` changes on fall |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial command input |
| sample_in | input | RES | Parallel digital sample, captured when busy rises |
| dout | output | 1 | Serial result output, MSB first |
| busy | output | 1 | One-clock flag marking the hold point |
| drv_en | output | 1 | Touch-driver enable |
| mux_sel | output | 3 | Decoded channel address |
| ref_on | output | 1 | Reference powered |
| adc_on | output | 1 | Converter powered |
| pen_irq_en | output | 1 | Pen interrupt enabled |

## Verification
The hardest case to reach is an overlapped command. Here a start bit arrives while the previous result is still shifting out, on exactly the first clock it is allowed, or one clock too early. The stimulus places commands at exact 15- and 11-clock spacings and holds `din` high across the clocks just before the allowed start. It then runs a long stretch of random `din` and sample values. In that stretch, start bits land at every offset relative to a running conversion, including the same clock on which a differential driver hold ends.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // bits that follow the start bit in a command
    localparam int CMD_BITS    = 7;
    // position (0-based, after the start bit) of the reference-mode bit
    localparam int SER_IDX     = 4;
    // a new start is accepted once at most this many result bits remain
    localparam int START_SLACK = 5;

    typedef struct packed {
        logic [2:0] addr;
        logic       low_res;
        logic       single;
        logic [1:0] pwr;
    } tsc_cmd_t;

    typedef enum logic {
        RX_IDLE,
        RX_SHIFT
    } rx_state_e;

    function automatic logic is_touch(input logic [2:0] a, input logic [7:0] mask);
        return mask[a];
    endfunction

    function automatic logic use_diff(input tsc_cmd_t c, input logic [7:0] mask);
        return !c.single && mask[c.addr];
    endfunction

endpackage

// File: rtl/tsc_cmd_rx.sv
module tsc_cmd_rx
    import tsc_pkg::*;
#(
    parameter logic [7:0] TOUCH_MASK = 8'b0011_1010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       start_ok,
    output logic       fire,
    output tsc_cmd_t   cmd,
    output logic       acq_drv,
    output logic [2:0] mux_sel
);
    localparam int CNT_W = $clog2(CMD_BITS);

    rx_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [CMD_BITS-2:0]  sh;

    // last command bit is on din during this clock
    assign fire = (state == RX_SHIFT) && (cnt == CNT_W'(CMD_BITS - 1));
    assign cmd  = tsc_cmd_t'({sh, din});

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            sh      <= '0;
            acq_drv <= 1'b0;
            mux_sel <= '0;
        end else begin
            case (state)
                RX_IDLE: begin
                    if (din && start_ok) begin
                        state <= RX_SHIFT;
                        cnt   <= '0;
                    end
                end
                RX_SHIFT: begin
                    sh  <= {sh[CMD_BITS-3:0], din};
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(SER_IDX)) begin
                        // address sits above the resolution bit already shifted in
                        acq_drv <= is_touch(sh[3:1], TOUCH_MASK);
                        mux_sel <= sh[3:1];
                    end
                    if (fire) begin
                        state   <= RX_IDLE;
                        acq_drv <= 1'b0;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R5: a start bit is not taken while the previous result still has too many bits left
    p_start_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && !start_ok) |=> (state == RX_IDLE));

    // R6: acquisition drive ends when the command completes
    p_acq_end_r6: assert property (@(posedge clk) disable iff (rst)
        fire |=> !acq_drv);

endmodule

// File: rtl/tsc_result_tx.sv
module tsc_result_tx
    import tsc_pkg::*;
#(
    parameter int RES     = 12,
    parameter int LOW_RES = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           low_res,
    input  logic           hold_drv,
    input  logic [RES-1:0] sample,
    output logic           dout,
    output logic           busy,
    output logic           conv_drv,
    output logic           converting,
    output logic           start_ok
);
    localparam int CW = $clog2(RES + 1);

    logic [RES-1:0] sh;
    logic [CW-1:0]  left;
    logic           nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            left     <= '0;
            nbit     <= 1'b0;
            busy     <= 1'b0;
            conv_drv <= 1'b0;
        end else begin
            busy <= load;
            if (load) begin
                sh       <= sample;
                left     <= low_res ? CW'(LOW_RES) : CW'(RES);
                conv_drv <= hold_drv;
                nbit     <= 1'b0;
            end else if (left != '0) begin
                nbit <= sh[RES-1];
                sh   <= {sh[RES-2:0], 1'b0};
                left <= left - 1'b1;
            end else begin
                nbit     <= 1'b0;
                conv_drv <= 1'b0;
            end
        end
    end

    // output changes on the falling edge
    always_ff @(negedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= nbit;
    end

    assign converting = busy || (left != '0);
    assign start_ok   = (left <= CW'(START_SLACK));

    // R2: busy never lasts two clocks
    p_busy_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

    // R5: a new load only lands after the previous result is fully out
    p_load_idle_r5: assert property (@(posedge clk) disable iff (rst)
        load |-> (left == '0 && !busy));

    // R3: bit count never exceeds the full resolution
    p_left_bound_r3: assert property (@(posedge clk) disable iff (rst)
        left <= CW'(RES));

endmodule

// File: rtl/tsc_power_ctl.sv
module tsc_power_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] pwr,
    input  logic       converting,
    output logic       ref_on,
    output logic       adc_on,
    output logic       pen_irq_en
);
    logic [1:0] pwr_q;

    always_ff @(posedge clk) begin
        if (rst)       pwr_q <= 2'b00;
        else if (load) pwr_q <= pwr;
    end

    assign ref_on     = pwr_q[1];
    assign pen_irq_en = ~pwr_q[0];
    assign adc_on     = pwr_q[0] | converting;

    // R9: converter is powered whenever a conversion runs
    p_adc_live_r9: assert property (@(posedge clk) disable iff (rst)
        converting |-> adc_on);

endmodule

// File: rtl/tsc_serial_if.sv
module tsc_serial_if
    import tsc_pkg::*;
#(
    parameter int         RES        = 12,
    parameter int         LOW_RES    = 8,
    parameter logic [7:0] TOUCH_MASK = 8'b0011_1010
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    input  logic [RES-1:0] sample_in,
    output logic           dout,
    output logic           busy,
    output logic           drv_en,
    output logic [2:0]     mux_sel,
    output logic           ref_on,
    output logic           adc_on,
    output logic           pen_irq_en
);
    logic     fire;
    tsc_cmd_t cmd;
    logic     acq_drv;
    logic     start_ok;
    logic     conv_drv;
    logic     converting;

    tsc_cmd_rx #(.TOUCH_MASK(TOUCH_MASK)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .start_ok(start_ok),
        .fire    (fire),
        .cmd     (cmd),
        .acq_drv (acq_drv),
        .mux_sel (mux_sel)
    );

    tsc_result_tx #(.RES(RES), .LOW_RES(LOW_RES)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .low_res   (cmd.low_res),
        .hold_drv  (use_diff(cmd, TOUCH_MASK)),
        .sample    (sample_in),
        .dout      (dout),
        .busy      (busy),
        .conv_drv  (conv_drv),
        .converting(converting),
        .start_ok  (start_ok)
    );

    tsc_power_ctl u_pwr (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .pwr       (cmd.pwr),
        .converting(converting),
        .ref_on    (ref_on),
        .adc_on    (adc_on),
        .pen_irq_en(pen_irq_en)
    );

    assign drv_en = acq_drv | conv_drv;

    // R8: power outputs move only together with the rise of busy
    p_pwr_at_busy_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable({ref_on, pen_irq_en}) |-> $rose(busy));

    // R6 / R7: a single-ended or non-touch command releases the drivers at hold
    p_drv_release_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && !use_diff(cmd, TOUCH_MASK)) |=> !drv_en);

    // R4: line stays low once no conversion has run for a full clock
    p_tail_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!converting && !$past(converting)) |-> !dout);

endmodule

// File: tb/tsc_serial_if_bench.sv
module tsc_serial_if_bench;
    localparam int         RES     = 12;
    localparam int         LOW_RES = 8;
    localparam logic [7:0] MASK    = 8'b0011_1010;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           din = 1'b0;
    logic [RES-1:0] sample_in = '0;
    logic           dout, busy, drv_en, ref_on, adc_on, pen_irq_en;
    logic [2:0]     mux_sel;

    tsc_serial_if #(.RES(RES), .LOW_RES(LOW_RES), .TOUCH_MASK(MASK)) u_tsc_serial_if (
        .clk(clk), .rst(rst), .din(din), .sample_in(sample_in),
        .dout(dout), .busy(busy), .drv_en(drv_en), .mux_sel(mux_sel),
        .ref_on(ref_on), .adc_on(adc_on), .pen_irq_en(pen_irq_en)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // ---------------- behavioural reference model ----------------
    int         rx_n       = -1;
    logic [6:0] rx_bits    = '0;
    int         last_start = -1000;
    int         last_gap   = 0;
    bit         q[$];
    int         hold_left  = 0;
    logic [1:0] pwr_m      = 2'b00;
    logic       acq_m      = 1'b0;
    logic [2:0] mux_m      = '0;
    logic       busy_m     = 1'b0;
    logic       dout_m     = 1'b0;

    always @(posedge clk) begin
        int n;
        cyc++;
        if (rst) begin
            rx_n = -1; rx_bits = '0; last_start = -1000; last_gap = 0;
            q.delete(); hold_left = 0; pwr_m = 2'b00; acq_m = 1'b0;
            mux_m = '0; busy_m = 1'b0; dout_m = 1'b0;
        end else begin
            busy_m = 1'b0;
            dout_m = (q.size() > 0) ? q.pop_front() : 1'b0;
            if (hold_left > 0) hold_left--;
            if (rx_n < 0) begin
                if (din && (cyc - last_start >= last_gap)) begin
                    rx_n = 0;
                    last_start = cyc;
                end
            end else begin
                rx_bits = {rx_bits[5:0], din};
                rx_n++;
                if (rx_n == 5) begin
                    mux_m = rx_bits[4:2];
                    acq_m = MASK[rx_bits[4:2]];
                end
                if (rx_n == 7) begin
                    n = rx_bits[3] ? LOW_RES : RES;
                    for (int i = 0; i < n; i++) q.push_back(sample_in[RES-1-i]);
                    busy_m = 1'b1;
                    pwr_m  = rx_bits[1:0];
                    acq_m  = 1'b0;
                    hold_left = (!rx_bits[2] && MASK[rx_bits[6:4]]) ? n + 1 : 0;
                    last_gap = n + 3;
                    rx_n = -1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
        end
    endtask

    // compare every clock, after the falling edge, before the next rise
    always @(posedge clk) begin
        #7;
        if (!rst) begin
            chk("R3/R4 dout", {7'd0, dout}, {7'd0, dout_m});
            chk("R2 busy (R1 R5 framing)", {7'd0, busy}, {7'd0, busy_m});
            chk("R6/R7 drv_en", {7'd0, drv_en}, {7'd0, acq_m | (hold_left > 0)});
            chk("R10 mux_sel", {5'd0, mux_sel}, {5'd0, mux_m});
            chk("R8 ref_on", {7'd0, ref_on}, {7'd0, pwr_m[1]});
            chk("R8 pen_irq_en", {7'd0, pen_irq_en}, {7'd0, ~pwr_m[0]});
            chk("R9 adc_on", {7'd0, adc_on},
                {7'd0, pwr_m[0] | busy_m | (q.size() > 0)});
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] mk(input logic [2:0] a, input logic r8,
                                      input logic se, input logic [1:0] pd);
        return {1'b1, a, r8, se, pd};
    endfunction

    task automatic idle(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            din = lvl;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [RES-1:0] s);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            if (i == 7) sample_in = s;
            din = b[i];
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk); #7;
        // R11: reset values
        chk("R11 reset dout", {7'd0, dout}, 8'd0);
        chk("R11 reset busy", {7'd0, busy}, 8'd0);
        chk("R11 reset drv_en", {7'd0, drv_en}, 8'd0);
        chk("R11 reset ref_on", {7'd0, ref_on}, 8'd0);
        chk("R11 reset adc_on", {7'd0, adc_on}, 8'd0);
        chk("R11 reset pen_irq_en", {7'd0, pen_irq_en}, 8'd1);
        chk("R11 reset mux_sel", {5'd0, mux_sel}, 8'd0);
        @(negedge clk); rst = 1'b0;

        idle(5, 1'b0);
        send(mk(3'd5, 1'b0, 1'b1, 2'b00), 12'hA5C); idle(20, 1'b0);   // R3 single 12-bit
        send(mk(3'd1, 1'b1, 1'b0, 2'b11), 12'h3C7); idle(20, 1'b0);   // R6 diff 8-bit, R8
        send(mk(3'd2, 1'b0, 1'b0, 2'b01), 12'hFFF); idle(20, 1'b0);   // R7 diff on non-touch
        send(mk(3'd4, 1'b0, 1'b0, 2'b10), 12'h801); idle(20, 1'b0);   // R6 13-clock hold, R9

        // R5: tightest spacing, 12-bit then 8-bit
        send(mk(3'd3, 1'b0, 1'b0, 2'b00), 12'h5A5); idle(7, 1'b0);
        send(mk(3'd5, 1'b0, 1'b1, 2'b11), 12'hC33); idle(7, 1'b0);
        send(mk(3'd1, 1'b1, 1'b1, 2'b00), 12'hE1F); idle(3, 1'b0);
        send(mk(3'd1, 1'b1, 1'b0, 2'b01), 12'h7B2); idle(25, 1'b0);

        // R5: din high on every clock before the window opens
        send(mk(3'd5, 1'b0, 1'b1, 2'b00), 12'h9C6); idle(7, 1'b1); idle(20, 1'b0);
        send(mk(3'd4, 1'b1, 1'b0, 2'b10), 12'h4E8); idle(3, 1'b1); idle(20, 1'b0);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            din = 1'($urandom_range(0, 1));
            sample_in = RES'($urandom);
        end
        idle(30, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog expired cyc=%0d", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule